// File: doc/BRIEF.md
# Remote Terminal Host Register Interface

This block is the host-facing register file of a serial-bus remote terminal core. A small strobe-style host port, made of a chip select, a control select, a read/write line, one address bit and data lines, is decoded into three actions: a write to an 8-bit control register, a master reset, and a read of a 16-bit system status register. The control register drives the flag bits of the terminal's reply status word. It also enables the two redundant bus receivers, selects the terminal-active flag and places the terminal in self-test.

The reply status word is not built from the live control register. It is loaded on the rising edge of the command strobe, so the host can change the flags at any time without corrupting a reply that is already in flight. The block also keeps a last-command register. It captures every received command word together with a snapshot of the system status, and it leaves out the Transmit Last Command mode code itself. The capture therefore holds the previous command, which is what a reply to that mode code must return. All host strobes are sampled synchronously on the core clock.

Top module: `rt_host_regs`

## Requirements
- R1: When cs_n, ctl_n, rw and addr0 are all sampled low at a clock edge, host_wdata[7:0] is loaded into the control register.
- R2: When cs_n, ctl_n and rw are sampled low with addr0 high, a master reset occurs. The control register becomes 8'h30, the status word and both last-command registers clear to zero, and the terminal address is recaptured from rt_addr.
- R3: host_oe is high only while cs_n and ctl_n are low and rw is high. While host_oe is low, host_rdata is zero.
- R4: The system register reads as follows: bit0 is the terminal-active select (control bit 6), bit1 is cur_bus, bit2 is msg_error, bit3 is self-test (control bit 7), bits 8:4 hold the captured terminal address, and all other bits are zero.
- R5: Control bit map: bit0 service request, bit1 busy, bit2 subsystem flag, bit3 terminal flag, bit4 drives bus_a_en, bit5 drives bus_b_en, bit6 selects terminal active, bit7 drives self_test.
- R6: status_word changes only in the cycle after a rising edge of cmd_strobe is sampled, or on a master reset. It then loads {address[4:0], message error, 0, service request, 3'b000, 0, busy, subsystem, 0, terminal flag}, using msg_error and the control value from writes made in earlier cycles.
- R7: A cmd_valid with any command word other than Transmit Last Command loads cmd_word into last_cmd_word and the current system register into last_cmd_status.
- R8: Transmit Last Command is a command with bit 10 (T/R) set, a subaddress in bits 9:5 of 00000 or 11111, and a mode code in bits 4:0 of 10010. It leaves both last-command registers unchanged.
- R9: After rst_n, the control register holds 8'h30, status_word and the last-command registers are zero, and the terminal address is taken from rt_addr.
- R10: A host cycle with cs_n high, ctl_n high or rw high never changes the control register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Host chip select, active low |
| ctl_n | input | 1 | Host register-space select, active low |
| rw | input | 1 | 1 = host read, 0 = host write |
| addr0 | input | 1 | 0 = control write, 1 = master reset on a write cycle |
| host_wdata | input | 8 | Control write data |
| host_rdata | output | 16 | System register read data |
| host_oe | output | 1 | Host data output enable |
| rt_addr | input | 5 | Terminal address pins |
| cur_bus | input | 1 | Bus currently in use (0 = A, 1 = B) |
| msg_error | input | 1 | Message error condition from the protocol core |
| cmd_strobe | input | 1 | Command strobe; its rising edge latches the status word |
| cmd_valid | input | 1 | One-cycle pulse with a received command word |
| cmd_word | input | 16 | Received command word |
| status_word | output | 16 | Outgoing reply status word |
| last_cmd_word | output | 16 | Last captured command word |
| last_cmd_status | output | 16 | System register snapshot at last capture |
| bus_a_en | output | 1 | Bus A receiver enable |
| bus_b_en | output | 1 | Bus B receiver enable |
| self_test | output | 1 | Self-test mode |

## Verification
The hardest case to reach is a host write that lands while the command strobe is already high. Only a fresh rising edge may carry the new flags into the status word, so the bench raises the strobe, rewrites the control register, holds the strobe for several cycles, and only then drops and raises it again. The Transmit Last Command exclusion is reached by preloading a known ordinary command and then sweeping all 32 mode codes on both mode subaddresses and both T/R values. All 256 control values are swept with the flags read back through the system register and through a strobed status word.

// File: rtl/rt_host_pkg.sv
package rt_host_pkg;
  localparam int CTRL_W = 8;
  localparam int WORD_W = 16;
  localparam int TA_W   = 5;

  localparam int CB_SRQ   = 0;
  localparam int CB_BUSY  = 1;
  localparam int CB_SSF   = 2;
  localparam int CB_TFLAG = 3;
  localparam int CB_BUSA  = 4;
  localparam int CB_BUSB  = 5;
  localparam int CB_TACT  = 6;
  localparam int CB_STEST = 7;

  localparam logic [CTRL_W-1:0] CTRL_RST = 8'h30;
  localparam logic [4:0] MC_TX_LAST = 5'b10010;

  typedef enum logic [1:0] {ACC_IDLE, ACC_WRITE, ACC_MRST, ACC_READ} acc_e;

  function automatic logic is_tx_last(input logic [WORD_W-1:0] w);
    logic mode_sa;
    mode_sa = (w[9:5] == 5'b00000) || (w[9:5] == 5'b11111);
    return w[10] && mode_sa && (w[4:0] == MC_TX_LAST);
  endfunction
endpackage

// File: rtl/rt_host_decode.sv
module rt_host_decode
  import rt_host_pkg::*;
(
  input  logic cs_n,
  input  logic ctl_n,
  input  logic rw,
  input  logic addr0,
  output acc_e acc
);
  always_comb begin
    acc = ACC_IDLE;
    if (!cs_n && !ctl_n) begin
      if (rw)         acc = ACC_READ;
      else if (addr0) acc = ACC_MRST;
      else            acc = ACC_WRITE;
    end
  end
endmodule

// File: rtl/rt_ctrl_reg.sv
module rt_ctrl_reg
  import rt_host_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              mrst,
  input  logic [CTRL_W-1:0] wdata,
  input  logic [TA_W-1:0]   ta_in,
  output logic [CTRL_W-1:0] ctrl_q,
  output logic [TA_W-1:0]   ta_q
);
  logic [CTRL_W-1:0] ctrl_d;
  logic [TA_W-1:0]   ta_d;
  logic              ta_vld_q, ta_vld_d;

  always_comb begin
    ctrl_d   = ctrl_q;
    ta_d     = ta_q;
    ta_vld_d = ta_vld_q;
    if (mrst) begin
      ctrl_d   = CTRL_RST;
      ta_vld_d = 1'b0;
    end else if (wr_en) begin
      ctrl_d = wdata;
    end
    if (!ta_vld_q) begin
      ta_d     = ta_in;
      ta_vld_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q   <= CTRL_RST;
      ta_q     <= '0;
      ta_vld_q <= 1'b0;
    end else begin
      ctrl_q   <= ctrl_d;
      ta_q     <= ta_d;
      ta_vld_q <= ta_vld_d;
    end
  end
endmodule

// File: rtl/rt_status_latch.sv
module rt_status_latch
  import rt_host_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mrst,
  input  logic              strobe,
  input  logic [3:0]        flags,
  input  logic              me,
  input  logic [TA_W-1:0]   ta,
  output logic [WORD_W-1:0] status_q
);
  logic              strb_q;
  logic [WORD_W-1:0] status_d;
  logic              rise;

  assign rise = strobe && !strb_q;

  always_comb begin
    status_d = status_q;
    if (mrst)
      status_d = '0;
    else if (rise)
      status_d = {ta, me, 1'b0, flags[CB_SRQ], 3'b000, 1'b0,
                  flags[CB_BUSY], flags[CB_SSF], 1'b0, flags[CB_TFLAG]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q <= '0;
      strb_q   <= 1'b0;
    end else begin
      status_q <= status_d;
      strb_q   <= strobe;
    end
  end
endmodule

// File: rtl/rt_last_cmd.sv
module rt_last_cmd
  import rt_host_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mrst,
  input  logic              cmd_valid,
  input  logic [WORD_W-1:0] cmd_word,
  input  logic [WORD_W-1:0] sys_word,
  output logic [WORD_W-1:0] lc_word_q,
  output logic [WORD_W-1:0] lc_stat_q
);
  logic [WORD_W-1:0] lc_word_d, lc_stat_d;
  logic              cap_en;

  assign cap_en = cmd_valid && !is_tx_last(cmd_word);

  always_comb begin
    lc_word_d = lc_word_q;
    lc_stat_d = lc_stat_q;
    if (mrst) begin
      lc_word_d = '0;
      lc_stat_d = '0;
    end else if (cap_en) begin
      lc_word_d = cmd_word;
      lc_stat_d = sys_word;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lc_word_q <= '0;
      lc_stat_q <= '0;
    end else begin
      lc_word_q <= lc_word_d;
      lc_stat_q <= lc_stat_d;
    end
  end
endmodule

// File: rtl/rt_host_regs.sv
module rt_host_regs
  import rt_host_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              ctl_n,
  input  logic              rw,
  input  logic              addr0,
  input  logic [CTRL_W-1:0] host_wdata,
  output logic [WORD_W-1:0] host_rdata,
  output logic              host_oe,
  input  logic [TA_W-1:0]   rt_addr,
  input  logic              cur_bus,
  input  logic              msg_error,
  input  logic              cmd_strobe,
  input  logic              cmd_valid,
  input  logic [WORD_W-1:0] cmd_word,
  output logic [WORD_W-1:0] status_word,
  output logic [WORD_W-1:0] last_cmd_word,
  output logic [WORD_W-1:0] last_cmd_status,
  output logic              bus_a_en,
  output logic              bus_b_en,
  output logic              self_test
);
  localparam int PAD_W = WORD_W - TA_W - 4;

  logic [1:0]        rst_sync_q;
  logic              rst_i_n;
  acc_e              acc;
  logic [CTRL_W-1:0] ctrl_q;
  logic [TA_W-1:0]   ta_q;
  logic [WORD_W-1:0] sys_word;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_i_n = rst_sync_q[1];

  rt_host_decode u_dec (
    .cs_n (cs_n), .ctl_n (ctl_n), .rw (rw), .addr0 (addr0), .acc (acc)
  );

  rt_ctrl_reg u_ctrl (
    .clk (clk), .rst_n (rst_i_n),
    .wr_en (acc == ACC_WRITE), .mrst (acc == ACC_MRST),
    .wdata (host_wdata), .ta_in (rt_addr),
    .ctrl_q (ctrl_q), .ta_q (ta_q)
  );

  assign sys_word = {{PAD_W{1'b0}}, ta_q, ctrl_q[CB_STEST], msg_error,
                     cur_bus, ctrl_q[CB_TACT]};

  rt_status_latch u_stat (
    .clk (clk), .rst_n (rst_i_n), .mrst (acc == ACC_MRST),
    .strobe (cmd_strobe), .flags (ctrl_q[3:0]), .me (msg_error),
    .ta (ta_q), .status_q (status_word)
  );

  rt_last_cmd u_lc (
    .clk (clk), .rst_n (rst_i_n), .mrst (acc == ACC_MRST),
    .cmd_valid (cmd_valid), .cmd_word (cmd_word), .sys_word (sys_word),
    .lc_word_q (last_cmd_word), .lc_stat_q (last_cmd_status)
  );

  assign host_oe    = (acc == ACC_READ);
  assign host_rdata = host_oe ? sys_word : '0;
  assign bus_a_en   = ctrl_q[CB_BUSA];
  assign bus_b_en   = ctrl_q[CB_BUSB];
  assign self_test  = ctrl_q[CB_STEST];
endmodule

// File: rtl/rt_host_regs_chk.sv
module rt_host_regs_chk
  import rt_host_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              cs_n,
  input logic              ctl_n,
  input logic              rw,
  input logic              addr0,
  input logic              host_oe,
  input logic [WORD_W-1:0] host_rdata,
  input logic              cmd_strobe,
  input logic              cmd_valid,
  input logic [WORD_W-1:0] cmd_word,
  input logic [WORD_W-1:0] status_word,
  input logic [WORD_W-1:0] last_cmd_word,
  input logic              bus_a_en,
  input logic              bus_b_en,
  input logic              self_test
);
  logic mrst_cyc;
  assign mrst_cyc = !cs_n && !ctl_n && !rw && addr0;

  assert_oe_needs_sel_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n || ctl_n || !rw) |-> !host_oe);

  assert_rdata_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !host_oe |-> (host_rdata == '0));

  assert_mrst_ctrl_R2: assert property (@(posedge clk) disable iff (!rst_n)
    mrst_cyc |=> (bus_a_en && bus_b_en && !self_test && status_word == '0));

  assert_status_edge_only_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!(cmd_strobe && !$past(cmd_strobe)) && !mrst_cyc) |=> $stable(status_word));

  assert_tx_last_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && is_tx_last(cmd_word) && !mrst_cyc) |=> $stable(last_cmd_word));

  assert_no_stray_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n || ctl_n || rw) |=> ($stable(bus_a_en) && $stable(bus_b_en) && $stable(self_test)));
endmodule

bind rt_host_regs rt_host_regs_chk u_chk (
  .clk (clk), .rst_n (rst_n), .cs_n (cs_n), .ctl_n (ctl_n), .rw (rw),
  .addr0 (addr0), .host_oe (host_oe), .host_rdata (host_rdata),
  .cmd_strobe (cmd_strobe), .cmd_valid (cmd_valid), .cmd_word (cmd_word),
  .status_word (status_word), .last_cmd_word (last_cmd_word),
  .bus_a_en (bus_a_en), .bus_b_en (bus_b_en), .self_test (self_test)
);

// File: tb/rt_host_regs_tb.sv
module rt_host_regs_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cs_n, ctl_n, rw, addr0;
  logic [7:0]  host_wdata;
  logic [15:0] host_rdata;
  logic        host_oe;
  logic [4:0]  rt_addr;
  logic        cur_bus, msg_error, cmd_strobe, cmd_valid;
  logic [15:0] cmd_word, status_word, last_cmd_word, last_cmd_status;
  logic        bus_a_en, bus_b_en, self_test;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rt_host_regs u_dut (.*);

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    cs_n = 1; ctl_n = 1; rw = 1; addr0 = 0;
  endtask

  task automatic host_cycle(input logic c, input logic k, input logic r,
                            input logic a, input logic [7:0] d);
    @(negedge clk);
    cs_n = c; ctl_n = k; rw = r; addr0 = a; host_wdata = d;
    @(negedge clk);
    idle();
  endtask

  task automatic host_read(output logic [15:0] v, output logic oe);
    @(negedge clk);
    cs_n = 0; ctl_n = 0; rw = 1; addr0 = 0;
    #1;
    v = host_rdata; oe = host_oe;
    @(negedge clk);
    idle();
  endtask

  task automatic strobe_pulse();
    @(negedge clk); cmd_strobe = 1;
    @(negedge clk); cmd_strobe = 0;
  endtask

  task automatic send_cmd(input logic [15:0] w);
    @(negedge clk); cmd_valid = 1; cmd_word = w;
    @(negedge clk); cmd_valid = 0;
  endtask

  function automatic logic [15:0] exp_sys(input logic [7:0] c, input logic [4:0] ta,
                                          input logic me, input logic bus);
    return {7'b0, ta, c[7], me, bus, c[6]};
  endfunction

  function automatic logic [15:0] exp_stat(input logic [7:0] c, input logic [4:0] ta,
                                           input logic me);
    return {ta, me, 1'b0, c[0], 3'b000, 1'b0, c[1], c[2], 1'b0, c[3]};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [15:0] rv;
    logic        oe;
    logic [15:0] base;
    idle();
    host_wdata = 0; rt_addr = 5'h15; cur_bus = 1; msg_error = 0;
    cmd_strobe = 0; cmd_valid = 0; cmd_word = 0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (5) @(negedge clk);

    // R9 reset state
    chk("R9 ctrl outputs", {13'b0, bus_a_en, bus_b_en, self_test}, 16'h0006);
    chk("R9 status", status_word, 16'h0);
    chk("R9 last cmd", last_cmd_word, 16'h0);
    chk("R3 idle oe", {15'b0, host_oe}, 16'h0);
    chk("R3 idle rdata", host_rdata, 16'h0);
    host_read(rv, oe);
    chk("R9 sys reg", rv, exp_sys(8'h30, 5'h15, 0, 1));

    // R1 R4 R5 R6 exhaustive control sweep
    for (int v = 0; v < 256; v++) begin
      logic me;
      me = v[0] ^ v[3] ^ v[6];
      cur_bus = v[2];
      msg_error = me;
      host_cycle(0, 0, 0, 0, 8'(v));
      chk("R5 bus/self-test", {13'b0, bus_a_en, bus_b_en, self_test},
          {13'b0, v[4], v[5], v[7]});
      host_read(rv, oe);
      chk("R3 read oe", {15'b0, oe}, 16'h1);
      chk("R1 R4 sys reg", rv, exp_sys(8'(v), 5'h15, me, v[2]));
      strobe_pulse();
      @(negedge clk);
      chk("R6 status word", status_word, exp_stat(8'(v), 5'h15, me));
    end
    msg_error = 0; cur_bus = 1;

    // R10 stray cycles
    host_cycle(0, 0, 0, 0, 8'h30);
    host_cycle(1, 0, 0, 0, 8'hFF);
    host_cycle(0, 1, 0, 0, 8'hFF);
    host_cycle(1, 0, 0, 1, 8'h00);
    host_cycle(0, 1, 0, 1, 8'h00);
    chk("R10 outputs", {13'b0, bus_a_en, bus_b_en, self_test}, 16'h0006);
    host_read(rv, oe);
    chk("R10 sys reg", rv, exp_sys(8'h30, 5'h15, 0, 1));
    @(negedge clk); cs_n = 0; ctl_n = 1; rw = 1; #1;
    chk("R3 oe with ctl_n high", {15'b0, host_oe}, 16'h0);
    chk("R3 rdata released", host_rdata, 16'h0);
    cs_n = 1; ctl_n = 0; #1;
    chk("R3 oe with cs_n high", {15'b0, host_oe}, 16'h0);
    cs_n = 0; rw = 0; #1;
    chk("R3 oe on write", {15'b0, host_oe}, 16'h0);
    idle();

    // R6 write while strobe high
    host_cycle(0, 0, 0, 0, 8'h01);
    @(negedge clk); cmd_strobe = 1;
    @(negedge clk);
    chk("R6 srq latched", status_word, exp_stat(8'h01, 5'h15, 0));
    host_cycle(0, 0, 0, 0, 8'h02);
    msg_error = 1;
    repeat (4) @(negedge clk);
    chk("R6 no relatch while high", status_word, exp_stat(8'h01, 5'h15, 0));
    cmd_strobe = 0;
    @(negedge clk); cmd_strobe = 1;
    @(negedge clk); cmd_strobe = 0;
    chk("R6 relatch on new edge", status_word, exp_stat(8'h02, 5'h15, 1));
    msg_error = 0;

    // R7 R8 last command
    base = 16'hA8A5;
    for (int sa = 0; sa < 2; sa++) begin
      for (int tr = 0; tr < 2; tr++) begin
        for (int m = 0; m < 32; m++) begin
          logic [15:0] w;
          logic        skip;
          w = {5'h15, 1'(tr), (sa == 0) ? 5'b00000 : 5'b11111, 5'(m)};
          skip = (tr == 1) && (m == 18);
          send_cmd(base);
          send_cmd(w);
          @(negedge clk);
          if (skip) chk("R8 tx-last not captured", last_cmd_word, base);
          else      chk("R7 mode cmd captured", last_cmd_word, w);
        end
      end
    end
    host_cycle(0, 0, 0, 0, 8'hC0);
    msg_error = 1; cur_bus = 0;
    send_cmd(16'h1234);
    @(negedge clk);
    chk("R7 status snapshot", last_cmd_status, exp_sys(8'hC0, 5'h15, 1, 0));
    msg_error = 0; cur_bus = 1;
    send_cmd(16'h0412);
    @(negedge clk);
    chk("R8 tx-last keeps snapshot", last_cmd_status, exp_sys(8'hC0, 5'h15, 1, 0));

    // R2 master reset
    host_cycle(0, 0, 0, 0, 8'hFF);
    strobe_pulse();
    rt_addr = 5'h0A;
    host_cycle(0, 0, 0, 1, 8'h00);
    @(negedge clk);
    chk("R2 ctrl outputs", {13'b0, bus_a_en, bus_b_en, self_test}, 16'h0006);
    chk("R2 status cleared", status_word, 16'h0);
    chk("R2 last cmd cleared", last_cmd_word, 16'h0);
    chk("R2 snapshot cleared", last_cmd_status, 16'h0);
    host_read(rv, oe);
    chk("R2 address recaptured", rv, exp_sys(8'h30, 5'h0A, 0, 1));
    strobe_pulse();
    @(negedge clk);
    chk("R6 new address in status", status_word, exp_stat(8'h30, 5'h0A, 0));

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule